// File: doc/BRIEF.md
# Multi-lane parallel SPI master shifter

This block is the data path of an SPI master. Its 16-bit shift register moves a word over one, two or four serial lanes in each direction at once, so a word takes 16, 8 or 4 serial clock periods. Each lane owns one equal segment of the register. The top bit of the segment is that lane's output tap, and the bottom bit is where the lane's received bit lands. Every segment shifts left toward its own top bit.

The host picks a lane count and a clock divider, then pulses a write strobe with the transmit word. The block pulls its active-low select low and produces the serial clock, which idles low. It launches output bits on rising serial clock edges and samples the input lanes on falling edges. When the transfer ends it raises a one-cycle done pulse and presents the received word in the same cycle. The configuration is taken at the start of each transfer.

Top module: `mlspi_shifter`

## Requirements
- R1: After reset, `sclk` and `done` are low, `cs_n` is high, `busy` is low, all `simo` lanes are low and `rx_data` is zero.
- R2: A `tx_wr` pulse while `busy` is low starts a transfer. The block loads `tx_data` and samples `lane_sel` and `div_val` at that edge. From the next cycle, `busy` is high and `cs_n` is low until the transfer ends.
- R3: Each half period of `sclk` lasts `div_val`+1 system clock cycles. A transfer with N lanes makes 16/N `sclk` pulses. The transfer begins with a low half period, and the first `sclk` edge is a rising edge.
- R4: `lane_sel` encodes the lane count as 00 = one lane, 01 = two lanes, 10 = four lanes. The code 11 behaves as one lane.
- R5: With one lane, `simo[0]` presents bit 15 first and then each lower bit in turn. Bits sampled on `somi[0]` enter bit 0 and move toward bit 15, so the first bit received ends in bit 15.
- R6: With two lanes, bits 15 and 7 drive `simo[1]` and `simo[0]`. Bits from `somi[1]` and `somi[0]` enter bits 8 and 0. Each 8-bit half shifts left once per `sclk` period.
- R7: With four lanes, bits 15, 11, 7 and 3 drive `simo[3:0]`. Bits from `somi[3:0]` enter bits 12, 8, 4 and 0. Each 4-bit segment shifts left once per `sclk` period.
- R8: `simo` changes only at a rising `sclk` edge, at the start of a transfer or at its end. `somi` is sampled in the system clock cycle whose edge drops `sclk`.
- R9: `done` is a one-cycle pulse that comes one half period after the last falling `sclk` edge. In that same cycle `busy` drops and `rx_data` takes the received word. `rx_data` changes at no other time.
- R10: Unused `simo` lanes are driven low, and every `simo` lane is low while idle. Unused `somi` lanes have no effect on `rx_data`.
- R11: A `tx_wr` pulse while `busy` is high is ignored. Changes to `lane_sel` or `div_val` during a transfer do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Transmit write strobe; starts a transfer when idle |
| tx_data | input | 16 | Word to transmit |
| lane_sel | input | 2 | Lane count code |
| div_val | input | 8 | Half-period length minus one, in system clocks |
| somi | input | 4 | Serial input lanes |
| sclk | output | 1 | Serial clock, idles low |
| simo | output | 4 | Serial output lanes |
| cs_n | output | 1 | Active-low select, low during a transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | 16 | Last received word |

## Verification
The assertions watch four behaviours on every cycle:
- `sclk` stays low when idle.
- `done` is a single cycle that coincides with `busy` falling.
- `simo` moves only with a rising `sclk` or a transfer boundary.
- `rx_data` changes only alongside `done`.

Other behaviours depend on the exact data and timing, so only the bench's scenarios can show them. These are:
- the lane mapping for each lane count
- the exact half-period length for each divider
- the bit order of the received word
- that a busy write and mid-transfer configuration changes are ignored

The bench covers these with a behavioural timing model compared every cycle.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

   localparam int unsigned MAX_LANES = 4;

   typedef enum logic [1:0] {
      LANE_X1  = 2'b00,
      LANE_X2  = 2'b01,
      LANE_X4  = 2'b10,
      LANE_RSV = 2'b11
   } lane_mode_e;

   // log2 of the lane count; the reserved code falls back to one lane
   function automatic logic [1:0] lane_order(input lane_mode_e m);
      case (m)
         LANE_X2: lane_order = 2'd1;
         LANE_X4: lane_order = 2'd2;
         default: lane_order = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/mlspi_clkdiv.sv
module mlspi_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   // R3: the half-period counter never passes the latched divider
   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= div);

endmodule

// File: rtl/mlspi_seq.sv
module mlspi_seq #(
   parameter int WORD_W = 16,
   parameter int PH_W   = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       tick,
   input  logic [1:0] order,
   output logic       busy,
   output logic       done,
   output logic       sclk,
   output logic       shift_ev,
   output logic       cap_ev,
   output logic       fin_ev
);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] last_ph;

   // two half periods per serial cycle, WORD_W >> order serial cycles
   assign last_ph  = PH_W'((2 * WORD_W) >> order);
   assign fin_ev   = busy && tick && (ph_q == last_ph);
   assign cap_ev   = busy && tick && ph_q[0];
   assign shift_ev = busy && tick && !ph_q[0] && (ph_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         sclk <= 1'b0;
         ph_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               ph_q <= '0;
               sclk <= 1'b0;
            end
         end else if (tick) begin
            if (fin_ev) begin
               busy <= 1'b0;
               done <= 1'b1;
               sclk <= 1'b0;
            end else begin
               ph_q <= ph_q + 1'b1;
               sclk <= ~ph_q[0];
            end
         end
      end
   end

   // R1: serial clock rests low whenever no transfer runs
   a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R9: done marks the cycle busy has just dropped
   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R9: done lasts a single cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: the phase index stays within the transfer length
   a_r3_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ph_q <= last_ph));

endmodule

// File: rtl/mlspi_lanes.sv
module mlspi_lanes #(
   parameter int WORD_W = 16,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              busy,
   input  logic [1:0]        order,
   input  logic              shift_ev,
   input  logic              cap_ev,
   input  logic              fin_ev,
   input  logic [LANES-1:0]  somi,
   output logic [LANES-1:0]  simo,
   output logic [WORD_W-1:0] rx_data
);

   localparam int NMODES = $clog2(LANES) + 1;

   if ((LANES & (LANES - 1)) != 0) begin : g_chk_pow2
      $error("LANES must be a power of two");
   end
   if ((WORD_W % LANES) != 0) begin : g_chk_div
      $error("WORD_W must divide evenly into LANES segments");
   end

   logic [WORD_W-1:0] shr_q;
   logic [LANES-1:0]  samp_q;
   logic [WORD_W-1:0] cand [NMODES];
   logic [LANES-1:0]  tap  [NMODES];
   logic [WORD_W-1:0] shifted;

   for (genvar m = 0; m < NMODES; m++) begin : g_mode
      localparam int NL  = 1 << m;
      localparam int SEG = WORD_W / NL;
      for (genvar i = 0; i < WORD_W; i++) begin : g_bit
         if ((i % SEG) == 0) begin : g_in
            assign cand[m][i] = samp_q[i / SEG];
         end else begin : g_mv
            assign cand[m][i] = shr_q[i - 1];
         end
      end
      for (genvar l = 0; l < LANES; l++) begin : g_tap
         if (l < NL) begin : g_on
            assign tap[m][l] = shr_q[(l + 1) * SEG - 1];
         end else begin : g_off
            assign tap[m][l] = 1'b0;
         end
      end
   end

   assign shifted = cand[order];
   assign simo    = busy ? tap[order] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr_q   <= '0;
         samp_q  <= '0;
         rx_data <= '0;
      end else begin
         if (start)         shr_q <= tx_data;
         else if (shift_ev) shr_q <= shifted;
         if (cap_ev)        samp_q <= somi;
         if (fin_ev)        rx_data <= shifted;
      end
   end

   // R2: an accepted write loads the transmit word
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (shr_q == $past(tx_data)));

endmodule

// File: rtl/mlspi_shifter.sv
module mlspi_shifter
   import mlspi_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_wr,
   input  logic [WORD_W-1:0]    tx_data,
   input  logic [1:0]           lane_sel,
   input  logic [DIV_W-1:0]     div_val,
   input  logic [MAX_LANES-1:0] somi,
   output logic                 sclk,
   output logic [MAX_LANES-1:0] simo,
   output logic                 cs_n,
   output logic                 busy,
   output logic                 done,
   output logic [WORD_W-1:0]    rx_data
);

   localparam int LANES = MAX_LANES;
   localparam int PH_W  = $clog2(2 * WORD_W + 1);

   if (DIV_W < 1) begin : g_chk_div
      $error("DIV_W must be at least 1");
   end

   logic             start;
   logic             tick;
   logic             shift_ev;
   logic             cap_ev;
   logic             fin_ev;
   logic [1:0]       order_q;
   logic [DIV_W-1:0] div_q;

   assign start = tx_wr && !busy;
   assign cs_n  = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         order_q <= '0;
         div_q   <= '0;
      end else if (start) begin
         order_q <= lane_order(lane_mode_e'(lane_sel));
         div_q   <= div_val;
      end
   end

   mlspi_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div   (div_q),
      .tick  (tick)
   );

   mlspi_seq #(.WORD_W(WORD_W), .PH_W(PH_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tick     (tick),
      .order    (order_q),
      .busy     (busy),
      .done     (done),
      .sclk     (sclk),
      .shift_ev (shift_ev),
      .cap_ev   (cap_ev),
      .fin_ev   (fin_ev)
   );

   mlspi_lanes #(.WORD_W(WORD_W), .LANES(LANES)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tx_data  (tx_data),
      .busy     (busy),
      .order    (order_q),
      .shift_ev (shift_ev),
      .cap_ev   (cap_ev),
      .fin_ev   (fin_ev),
      .somi     (somi),
      .simo     (simo),
      .rx_data  (rx_data)
   );

   // R8: output lanes move only with a rising serial clock or a transfer boundary
   a_r8_simo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(simo) |-> ($rose(sclk) || $rose(busy) || $fell(busy)));

   // R9: the received word is updated only together with done
   a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> done);

endmodule

// File: tb/mlspi_shifter_bench.sv
module mlspi_shifter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_wr = 1'b0;
   logic [15:0] tx_data = '0;
   logic [1:0]  lane_sel = '0;
   logic [7:0]  div_val = '0;
   logic [3:0]  somi = '0;
   logic        sclk;
   logic [3:0]  simo;
   logic        cs_n;
   logic        busy;
   logic        done;
   logic [15:0] rx_data;

   int checks = 0;
   int errors = 0;

   mlspi_shifter u_mlspi_shifter (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
      .lane_sel(lane_sel), .div_val(div_val), .somi(somi),
      .sclk(sclk), .simo(simo), .cs_n(cs_n), .busy(busy),
      .done(done), .rx_data(rx_data)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // behavioural reference: elapsed cycles since start give the timing
   bit          m_busy = 1'b0;
   bit          m_done = 1'b0;
   int          m_e    = 0;
   int          m_n    = 1;
   int          m_div  = 0;
   logic [15:0] m_tx   = '0;
   logic [15:0] m_acc  = '0;
   logic [15:0] m_rx   = '0;

   function automatic int lanes_of(input logic [1:0] code);
      case (code)
         2'b01:   return 2;
         2'b10:   return 4;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0; m_done = 1'b0; m_e = 0; m_rx = '0;
      end else begin
         m_done = 1'b0;
         if (m_busy) begin
            m_e++;
            if (m_e % (m_div + 1) == 0) begin
               int p;
               int seg;
               p   = m_e / (m_div + 1) - 1;
               seg = 16 / m_n;
               if (p % 2 == 1) begin
                  for (int l = 0; l < m_n; l++)
                     m_acc[l * seg + seg - 1 - (p - 1) / 2] = somi[l];
               end
               if (p == 2 * seg) begin
                  m_busy = 1'b0; m_done = 1'b1; m_rx = m_acc;
               end
            end
         end else if (tx_wr) begin
            m_busy = 1'b1; m_e = 0; m_tx = tx_data;
            m_n = lanes_of(lane_sel); m_div = int'(div_val); m_acc = '0;
         end
      end
   end

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int ph;
         int j;
         int seg;
         logic [3:0] e_simo;
         string stag;
         ph  = m_e / (m_div + 1);
         j   = (ph == 0) ? 0 : (ph - 1) / 2;
         seg = 16 / m_n;
         e_simo = '0;
         if (m_busy)
            for (int l = 0; l < m_n; l++) e_simo[l] = m_tx[(l + 1) * seg - 1 - j];
         stag = !m_busy ? "R10" : (m_n == 1) ? "R5 R8" : (m_n == 2) ? "R6 R8" : "R7 R8";
         check("R3", "sclk", 16'(sclk), 16'(m_busy && (ph % 2 == 1)));
         check(stag, "simo", 16'(simo), 16'(e_simo));
         check("R2", "busy", 16'(busy), 16'(m_busy));
         check("R2", "cs_n", 16'(cs_n), 16'(!m_busy));
         check("R9", "done", 16'(done), 16'(m_done));
         check("R9", "rx_data", rx_data, m_rx);
      end
   end

   initial forever begin
      @(negedge clk);
      somi = 4'($urandom);
   end

   task automatic xfer(input logic [15:0] d, input logic [1:0] ls, input logic [7:0] dv);
      @(negedge clk);
      tx_wr = 1'b1; tx_data = d; lane_sel = ls; div_val = dv;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state seen at the ports
      check("R1", "reset sclk", 16'(sclk), 16'h0);
      check("R1", "reset cs_n", 16'(cs_n), 16'h1);
      check("R1", "reset simo", 16'(simo), 16'h0);
      check("R1", "reset rx", rx_data, 16'h0);

      // R5: one lane, fastest divider
      xfer(16'hA5C3, 2'b00, 8'd0); wait_idle();
      // R6: two lanes, half period of two clocks
      xfer(16'h3C96, 2'b01, 8'd1); wait_idle();
      // R7: four lanes, half period of three clocks
      xfer(16'hF00F, 2'b10, 8'd2); wait_idle();
      // R4: reserved code behaves as one lane
      xfer(16'h8001, 2'b11, 8'd0); wait_idle();
      check("R4", "reserved mode rx", rx_data, m_rx);
      // R3: all-ones and all-zeros patterns with other dividers
      xfer(16'hFFFF, 2'b10, 8'd0); wait_idle();
      xfer(16'h0000, 2'b01, 8'd3); wait_idle();

      // R11: write and configuration changes during a transfer are ignored
      xfer(16'h1234, 2'b01, 8'd1);
      repeat (3) @(negedge clk);
      tx_wr = 1'b1; tx_data = 16'hDEAD; lane_sel = 2'b10; div_val = 8'd0;
      @(negedge clk);
      tx_wr = 1'b0;
      wait_idle();
      check("R11", "rx after busy write", rx_data, m_rx);

      // R9: back-to-back transfers, then rx holds while idle
      xfer(16'h5A5A, 2'b10, 8'd1); wait_idle();
      xfer(16'hC001, 2'b00, 8'd1); wait_idle();
      repeat (10) @(negedge clk);
      check("R9", "rx holds when idle", rx_data, m_rx);
      check("R10", "idle simo low", 16'(simo), 16'h0);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule